// File: doc/BRIEF.md
# Multiscalar Counter Bank Sequencer

This block gathers detector events on eight parallel pulse lines. Each line has its own small saturating counter. A slow timebase tick starts a fixed readout. At each tick the block picks one pair of adjacent counters and locks them against new events. It copies the two counts and their overflow flags into output buffer registers and raises a one-cycle ready strobe. It then zeroes the pair, and counting resumes on the next cycle. A host that adds each buffered pair into successive memory locations builds interleaved spectra.

A two-bit slot counter advances on every accepted tick. A two-bit grouping selector maps the slot to a pair. This lets one host routine build any of four layouts:
- four separate spectra, by visiting every pair;
- two spectra of double length, by alternating the first two pairs;
- one spectrum of quadruple length, by reading only the first pair;
- a mixed layout of one double-length spectrum and two short spectra.

Top module: `msc_bank`

## Requirements
- R1: After reset, all counters, buffers and overflow outputs are zero, `pair_o` is 0 and `ready_o` is low.
- R2: A counter adds one for every rising clock edge at which its event input is high and the counter is not blocked. Channel 2p is reported on the A side of pair p and channel 2p+1 on the B side.
- R3: Take a tick sampled at edge t while the block is idle. Then `ready_o` is high for exactly one cycle, after edge t+2. During that cycle `pair_o`, the buffers and the overflow flags show the selected pair's counts as they were before edge t+2. These outputs then hold until the next transfer.
- R4: Events on the selected pair's inputs at edges t+1, t+2 and t+3 are dropped. Channels outside the selected pair keep counting at those edges.
- R5: At edge t+3 the selected pair's counters and overflow flags return to zero. Events from edge t+4 onward count from zero.
- R6: Grouping code 0 visits pairs 0, 1, 2, 3 for slots 0, 1, 2, 3.
- R7: Grouping code 1 visits pairs 0, 1, 0, 1 for slots 0 to 3.
- R8: Grouping code 2 visits pair 0 in every slot.
- R9: Grouping code 3 visits pairs 0, 1, 0, 2 for slots 0 to 3.
- R10: A counter at 63 stays at 63 on a further event and sets its sticky overflow flag. The flag is cleared only by the pair's clear.
- R11: A tick that arrives while a readout is in progress is ignored and does not advance the slot.
- R12: The slot counter is shared by all groupings. The grouping code is sampled only at the accepted tick, so changing it between ticks does not reset the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Event pulse lines, one per counter |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| group_i | input | 2 | Grouping code selecting the pair order |
| buf_a_o | output | 6 | Buffered count of the even channel of the pair |
| buf_b_o | output | 6 | Buffered count of the odd channel of the pair |
| ovf_a_o | output | 1 | Overflow flag buffered with `buf_a_o` |
| ovf_b_o | output | 1 | Overflow flag buffered with `buf_b_o` |
| pair_o | output | 2 | Index of the pair held in the buffers |
| ready_o | output | 1 | One-cycle strobe marking new buffered data |

## Verification
Two actions can land on a counter in the same cycle: an incoming event and the block or clear the readout applies to it. The bench holds all eight event lines high across the whole readout window. The selected pair must come back empty at its next readout. Every other channel must show exactly three extra counts. A second collision is a tick arriving one cycle into a readout. It is judged by which pair the following tick selects.

// File: rtl/msc_pkg.sv
`timescale 1ns/1ps
package msc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_BLOCK = 2'd1,
      PH_XFER  = 2'd2,
      PH_CLEAR = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      GRP_QUAD   = 2'd0,
      GRP_DOUBLE = 2'd1,
      GRP_SINGLE = 2'd2,
      GRP_MIXED  = 2'd3
   } group_e;

   localparam int SLOT_W = 2;
   localparam int PAIR_W = 2;
   localparam int N_PAIR = 4;

   function automatic logic [PAIR_W-1:0] pair_for_slot(input group_e grp,
                                                       input logic [SLOT_W-1:0] slot);
      logic [PAIR_W-1:0] p;
      case (grp)
         GRP_QUAD:   p = slot;
         GRP_DOUBLE: p = {1'b0, slot[0]};
         GRP_SINGLE: p = '0;
         default:    p = slot[0] ? (slot[1] ? 2'd2 : 2'd1) : 2'd0;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/msc_chan.sv
`timescale 1ns/1ps
module msc_chan #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             block_i,
   input  logic             clear_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (clear_i) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (evt_i && !block_i) begin
         if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
         else                  cnt_q <= cnt_q + CNT_ONE;
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

   // R4
   blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (block_i && !clear_i) |=> ($stable(cnt_q) && $stable(ovf_q)));
   // R5
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt_q == '0 && !ovf_q));
   // R10
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !clear_i) |=> (cnt_q == CNT_MAX));
   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clear_i) |=> ovf_q);
endmodule

// File: rtl/msc_seq.sv
`timescale 1ns/1ps
module msc_seq
   import msc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [1:0]        group_i,
   output phase_e            phase_o,
   output logic [PAIR_W-1:0] pair_o
);
   localparam logic [SLOT_W-1:0] SLOT_ONE = {{(SLOT_W-1){1'b0}}, 1'b1};

   phase_e            phase_q;
   logic [SLOT_W-1:0] slot_q;
   logic [PAIR_W-1:0] pair_q;
   group_e            grp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         slot_q  <= '0;
         pair_q  <= '0;
         grp_q   <= GRP_QUAD;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (tick_i) begin
                  phase_q <= PH_BLOCK;
                  pair_q  <= pair_for_slot(group_e'(group_i), slot_q);
                  grp_q   <= group_e'(group_i);
                  slot_q  <= slot_q + SLOT_ONE;
               end
            end
            PH_BLOCK: phase_q <= PH_XFER;
            PH_XFER:  phase_q <= PH_CLEAR;
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o = phase_q;
   assign pair_o  = pair_q;

   // R3
   walk_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_BLOCK) |=> (phase_q == PH_XFER));
   // R3
   walk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CLEAR) |=> (phase_q == PH_IDLE));
   // R11
   busy_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE) |=> ($stable(slot_q) && $stable(pair_q)));
   // R8
   single_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE && grp_q == GRP_SINGLE) |-> (pair_q == '0));
endmodule

// File: rtl/msc_readout.sv
`timescale 1ns/1ps
module msc_readout
   import msc_pkg::*;
#(
   parameter int N_CH  = 8,
   parameter int CNT_W = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic [PAIR_W-1:0]      pair_i,
   input  logic [N_CH*CNT_W-1:0]  cnt_i,
   input  logic [N_CH-1:0]        ovf_i,
   output logic [CNT_W-1:0]       buf_a_o,
   output logic [CNT_W-1:0]       buf_b_o,
   output logic                   ovf_a_o,
   output logic                   ovf_b_o,
   output logic [PAIR_W-1:0]      pair_o,
   output logic                   ready_o
);
   localparam int NP = N_CH / 2;

   logic [CNT_W-1:0] sel_a, sel_b;
   logic             sel_oa, sel_ob;

   always_comb begin
      sel_a  = '0;
      sel_b  = '0;
      sel_oa = 1'b0;
      sel_ob = 1'b0;
      for (int p = 0; p < NP; p++) begin
         if (pair_i == PAIR_W'(p)) begin
            sel_a  = cnt_i[(2*p)*CNT_W +: CNT_W];
            sel_b  = cnt_i[(2*p+1)*CNT_W +: CNT_W];
            sel_oa = ovf_i[2*p];
            sel_ob = ovf_i[2*p+1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_a_o <= '0;
         buf_b_o <= '0;
         ovf_a_o <= 1'b0;
         ovf_b_o <= 1'b0;
         pair_o  <= '0;
         ready_o <= 1'b0;
      end else begin
         ready_o <= load_i;
         if (load_i) begin
            buf_a_o <= sel_a;
            buf_b_o <= sel_b;
            ovf_a_o <= sel_oa;
            ovf_b_o <= sel_ob;
            pair_o  <= pair_i;
         end
      end
   end

   // R3
   rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> !ready_o);
   // R3
   buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(buf_a_o) && $stable(buf_b_o) && $stable(pair_o)));
endmodule

// File: rtl/msc_bank.sv
`timescale 1ns/1ps
module msc_bank
   import msc_pkg::*;
#(
   parameter int N_CH  = 8,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CH-1:0]  evt_i,
   input  logic             tick_i,
   input  logic [1:0]       group_i,
   output logic [CNT_W-1:0] buf_a_o,
   output logic [CNT_W-1:0] buf_b_o,
   output logic             ovf_a_o,
   output logic             ovf_b_o,
   output logic [1:0]       pair_o,
   output logic             ready_o
);
   if (N_CH != 2 * N_PAIR) begin : g_bad_ch
      $error("msc_bank: N_CH must equal twice the four sequencer pairs");
   end
   if (CNT_W < 2) begin : g_bad_w
      $error("msc_bank: CNT_W must be at least 2");
   end

   phase_e                 phase;
   logic [PAIR_W-1:0]      cur_pair;
   logic [N_CH*CNT_W-1:0]  cnt_flat;
   logic [N_CH-1:0]        ovf_vec;
   logic                   busy;

   assign busy = (phase != PH_IDLE);

   msc_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .group_i (group_i),
      .phase_o (phase),
      .pair_o  (cur_pair)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_chan
      localparam logic [PAIR_W-1:0] MY_PAIR = PAIR_W'(c / 2);
      logic hit;
      assign hit = (cur_pair == MY_PAIR);
      msc_chan #(.CNT_W(CNT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt_i   (evt_i[c]),
         .block_i (busy && hit),
         .clear_i ((phase == PH_CLEAR) && hit),
         .cnt_o   (cnt_flat[c*CNT_W +: CNT_W]),
         .ovf_o   (ovf_vec[c])
      );
   end

   msc_readout #(.N_CH(N_CH), .CNT_W(CNT_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (phase == PH_XFER),
      .pair_i  (cur_pair),
      .cnt_i   (cnt_flat),
      .ovf_i   (ovf_vec),
      .buf_a_o (buf_a_o),
      .buf_b_o (buf_b_o),
      .ovf_a_o (ovf_a_o),
      .ovf_b_o (ovf_b_o),
      .pair_o  (pair_o),
      .ready_o (ready_o)
   );

   // R3
   rdy_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_XFER) |=> ready_o);
endmodule

// File: tb/msc_bank_tb.sv
`timescale 1ns/1ps
module msc_bank_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] evt = '0;
   logic       tick = 1'b0;
   logic [1:0] gsel = '0;
   logic [5:0] buf_a, buf_b;
   logic       ovf_a, ovf_b, ready;
   logic [1:0] pair;

   int  errors = 0;
   int  checks = 0;
   bit  done = 0;
   int  mcnt [8];
   bit  movf [8];

   always #4 clk = ~clk;

   msc_bank dut_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .tick_i(tick), .group_i(gsel),
      .buf_a_o(buf_a), .buf_b_o(buf_b), .ovf_a_o(ovf_a), .ovf_b_o(ovf_b),
      .pair_o(pair), .ready_o(ready)
   );

   // {grouping code, expected pair, event mask, pulse count}
   localparam logic [19:0] VEC [12] = '{
      {2'd0, 2'd0, 8'h01, 8'd4}, {2'd0, 2'd1, 8'h0C, 8'd2},
      {2'd0, 2'd2, 8'h30, 8'd7}, {2'd0, 2'd3, 8'hC0, 8'd1},
      {2'd1, 2'd0, 8'h55, 8'd3}, {2'd1, 2'd1, 8'hAA, 8'd6},
      {2'd1, 2'd0, 8'h0F, 8'd2}, {2'd1, 2'd1, 8'hF0, 8'd5},
      {2'd3, 2'd0, 8'h03, 8'd9}, {2'd3, 2'd1, 8'h04, 8'd1},
      {2'd3, 2'd0, 8'h80, 8'd3}, {2'd3, 2'd2, 8'h10, 8'd8}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bump(input int ch);
      if (mcnt[ch] == 63) movf[ch] = 1'b1;
      else                mcnt[ch] = mcnt[ch] + 1;
   endtask

   task automatic pulses(input logic [7:0] mask, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) evt = mask;
         @(negedge clk) evt = '0;
         for (int c = 0; c < 8; c++) if (mask[c]) bump(c);
      end
   endtask

   task automatic readout(input logic [1:0] s, input int ep, input bit blk,
                          input bit dbl, input string req);
      @(negedge clk); tick = 1'b1; gsel = s;
      @(negedge clk); tick = dbl; if (blk) evt = 8'hFF;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
      chk(ready == 1'b1, "R3", ready, 1);
      chk(pair == 2'(ep), req, pair, ep);
      chk(buf_a == 6'(mcnt[2*ep]), "R2", buf_a, mcnt[2*ep]);
      chk(buf_b == 6'(mcnt[2*ep+1]), "R2", buf_b, mcnt[2*ep+1]);
      chk(ovf_a == movf[2*ep] && ovf_b == movf[2*ep+1], "R10",
          {ovf_a, ovf_b}, {movf[2*ep], movf[2*ep+1]});
      mcnt[2*ep] = 0; mcnt[2*ep+1] = 0; movf[2*ep] = 0; movf[2*ep+1] = 0;
      if (blk)
         for (int k = 0; k < 3; k++)
            for (int c = 0; c < 8; c++) if (c / 2 != ep) bump(c);
      @(negedge clk); evt = '0;
      chk(ready == 1'b0, "R3", ready, 0);
      chk(pair == 2'(ep), "R3", pair, ep);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      for (int c = 0; c < 8; c++) begin mcnt[c] = 0; movf[c] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(buf_a == 0 && buf_b == 0, "R1", {buf_a, buf_b}, 0);
      chk(!ovf_a && !ovf_b && pair == 0, "R1", {ovf_a, ovf_b, pair}, 0);
      chk(ready == 0, "R1", ready, 0);

      // Table walk: R6 (code 0), R7 (code 1), R9 (code 3)
      for (int v = 0; v < 12; v++) begin
         string rq;
         case (VEC[v][19:18])
            2'd0:    rq = "R6";
            2'd1:    rq = "R7";
            2'd2:    rq = "R8";
            default: rq = "R9";
         endcase
         pulses(VEC[v][15:8], int'(VEC[v][7:0]));
         readout(VEC[v][19:18], int'(VEC[v][17:16]), 1'b0, 1'b0, rq);
      end

      // R8 single long spectrum: pair 0 each slot; R5 second read is empty
      pulses(8'h02, 3);
      readout(2'd2, 0, 1'b0, 1'b0, "R8");
      readout(2'd2, 0, 1'b0, 1'b0, "R5");
      // R12 slot counter shared: slot is now 2
      readout(2'd0, 2, 1'b0, 1'b0, "R12");
      // R4 events held high over the readout window of pair 3
      readout(2'd0, 3, 1'b1, 1'b0, "R6");
      readout(2'd0, 0, 1'b0, 1'b0, "R4");
      readout(2'd0, 1, 1'b0, 1'b0, "R4");
      readout(2'd0, 2, 1'b0, 1'b0, "R4");
      readout(2'd0, 3, 1'b0, 1'b0, "R4");
      // R11 tick repeated during a readout does not advance the slot
      readout(2'd0, 0, 1'b0, 1'b1, "R6");
      readout(2'd0, 1, 1'b0, 1'b0, "R11");
      // R10 saturation and sticky overflow, cleared by readout
      pulses(8'h01, 70);
      chk(mcnt[0] == 63 && movf[0], "R10", mcnt[0], 63);
      readout(2'd2, 0, 1'b0, 1'b0, "R10");
      readout(2'd2, 0, 1'b0, 1'b0, "R5");

      done = 1;
      summary();
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end
endmodule